// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits between the event sources of a UART (receiver, transmitter holding stage, modem-line monitor) and the register bus. It takes the raw condition from each source and masks it with a software-written enable register. It then selects the single most urgent active source and presents it as a readable identification byte. It also drives the interrupt line to the host. The FIFO-enable state is reported in the top two bits of the same byte, so software can learn the operating mode in the same read.

The transmitter-empty source is held in a local edge-triggered latch. It is raised when the holding stage becomes empty, or when its enable is switched on while the stage is already empty. It is cleared when software reads the identification byte while that source is the one shown, or when the holding stage is refilled. On such a read the block pulses an acknowledge strobe back toward the transmitter. A combined power-down request is also produced from the enable register and a bit supplied from the modem-control register.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset the enable register is zero, the transmitter-empty latch is clear, `irq` is 0, `pwrdn_req` is 0 and `iid_byte` bits 5:0 are zero.
- R2: A write on `ien_we` stores `ien_wdata` from the following cycle on. Only bits 0 (receive data/timeout), 1 (transmitter empty), 2 (line status), 3 (modem status) and 5 (power-down) are kept. Bits 4, 6 and 7 have no effect.
- R3: Source codes in `iid_byte[3:1]` are: 011 line status, 010 receive data, 110 character timeout, 001 transmitter empty, 000 modem status.
- R4: Priority from highest to lowest is line status, then receive data or timeout, then transmitter empty, then modem status. Only the highest enabled pending source is shown.
- R5: When `ev_rx_timeout` is set together with or without `ev_rx_data` and the receive enable is on, the code is 110 rather than 010.
- R6: `iid_byte[0]` and `irq` are 1 exactly when at least one enabled source is pending. When none is pending the code is 000. A pending source whose enable bit is 0 is ignored.
- R7: `iid_byte[7:6]` is 11 when `fifo_en` is 1 and 00 when it is 0. `iid_byte[5:4]` is always 00.
- R8: The transmitter-empty latch is set one cycle after a rising edge of `thr_empty`, or one cycle after enable bit 1 is written from 0 to 1 while `thr_empty` is 1. It is cleared one cycle after `thr_empty` is 0.
- R9: `iid_rd` in a cycle where `iid_byte` shows pending code 001 pulses `thre_ack` in that cycle and clears the latch from the next cycle on. A read showing any other state leaves the latch unchanged and keeps `thre_ack` at 0.
- R10: `pwrdn_req` is 1 exactly when enable bit 5 is set and `mcr_pd_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ien_we | input | 1 | Enable-register write strobe |
| ien_wdata | input | 8 | Enable-register write data |
| mcr_pd_en | input | 1 | Power-down enable from the modem-control register |
| ev_line_status | input | 1 | Receiver line-status condition |
| ev_rx_data | input | 1 | Received data available |
| ev_rx_timeout | input | 1 | Character timeout condition |
| thr_empty | input | 1 | Transmit holding stage empty (level) |
| ev_modem | input | 1 | Modem-status change pending |
| iid_rd | input | 1 | Read strobe of the identification byte |
| fifo_en | input | 1 | FIFOs enabled |
| iid_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request line |
| thre_ack | output | 1 | Clear strobe to the transmitter-empty source |
| pwrdn_req | output | 1 | Combined power-down request |

## Verification
On every cycle, the embedded properties check the following. At most one source is granted. A granted line-status source always yields code 011. The acknowledge strobe only fires on a read of code 001. The latch falls after a refill or an acknowledge. Reserved identification bits stay zero. Written enable values land masked one cycle later. The bench's scenarios show the rest: the full priority ordering under mixed random sources, and the edge-versus-level behaviour of the transmitter-empty latch, including re-arming through an enable write. They also show that reads of other codes leave that latch alone.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 3;

    // enable-register bit positions
    localparam int EN_RXDAT = 0;
    localparam int EN_THRE  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_PWRDN = 5;

    localparam logic [BYTE_W-1:0] EN_KEEP_MASK =
        BYTE_W'((1 << EN_RXDAT) | (1 << EN_THRE) | (1 << EN_LINE) |
                (1 << EN_MODEM) | (1 << EN_PWRDN));

    typedef enum logic [CODE_W-1:0] {
        ID_MODEM   = 3'b000,
        ID_THRE    = 3'b001,
        ID_RXDATA  = 3'b010,
        ID_LINE    = 3'b011,
        ID_TIMEOUT = 3'b110
    } iid_code_e;

    typedef struct packed {
        logic line;
        logic rxdat;
        logic tmo;
        logic thre;
        logic modem;
    } src_req_t;

    typedef struct packed {
        logic line;
        logic rx;
        logic thre;
        logic modem;
    } src_grant_t;

    function automatic logic [BYTE_W-1:0] pack_iid(input logic fifo_on,
                                                   input iid_code_e code,
                                                   input logic pend);
        return {{2{fifo_on}}, 2'b00, code, pend};
    endfunction

endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ien_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (we) begin
            ien_q <= wdata & EN_KEEP_MASK;
        end
    end

    assert_en_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        $past(we && !rst) |-> (ien_q == ($past(wdata) & EN_KEEP_MASK)));

endmodule

// File: rtl/irq_thre_latch.sv
module irq_thre_latch (
    input  logic clk,
    input  logic rst,
    input  logic thr_empty,
    input  logic en_rise,
    input  logic ack,
    output logic pend_q
);

    logic thr_q;
    logic set_c;

    assign set_c = thr_empty && (!thr_q || en_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            thr_q <= thr_empty;
            if (!thr_empty) begin
                pend_q <= 1'b0;
            end else if (set_c) begin
                pend_q <= 1'b1;
            end else if (ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assert_refill_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !thr_empty |=> !pend_q);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (ack && !set_c) |=> !pend_q);

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  src_req_t          req,
    input  logic [BYTE_W-1:0] ien,
    input  logic              fifo_en,
    output src_grant_t        grant,
    output logic [BYTE_W-1:0] iid
);

    logic      act_line, act_rx, act_thre, act_modem;
    logic      any_act;
    iid_code_e code;

    assign act_line  = req.line  && ien[EN_LINE];
    assign act_rx    = (req.rxdat || req.tmo) && ien[EN_RXDAT];
    assign act_thre  = req.thre  && ien[EN_THRE];
    assign act_modem = req.modem && ien[EN_MODEM];

    always_comb begin
        grant = '0;
        code  = ID_MODEM;
        if (act_line) begin
            grant.line = 1'b1;
            code       = ID_LINE;
        end else if (act_rx) begin
            grant.rx = 1'b1;
            code     = req.tmo ? ID_TIMEOUT : ID_RXDATA;
        end else if (act_thre) begin
            grant.thre = 1'b1;
            code       = ID_THRE;
        end else if (act_modem) begin
            grant.modem = 1'b1;
            code        = ID_MODEM;
        end
    end

    assign any_act = act_line || act_rx || act_thre || act_modem;
    assign iid     = pack_iid(fifo_en, code, any_act);

    assert_single_grant_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_line_code_R3: assert property (@(posedge clk) disable iff (rst)
        grant.line |-> (iid[3:1] == 3'b011));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        iid[5:4] == 2'b00);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ien_we,
    input  logic [7:0] ien_wdata,
    input  logic       mcr_pd_en,
    input  logic       ev_line_status,
    input  logic       ev_rx_data,
    input  logic       ev_rx_timeout,
    input  logic       thr_empty,
    input  logic       ev_modem,
    input  logic       iid_rd,
    input  logic       fifo_en,
    output logic [7:0] iid_byte,
    output logic       irq,
    output logic       thre_ack,
    output logic       pwrdn_req
);

    logic [BYTE_W-1:0] ien_q;
    logic              thre_pend;
    logic              en_rise;
    src_req_t          req;
    src_grant_t        grant;

    irq_en_reg u_en (
        .clk   (clk),
        .rst   (rst),
        .we    (ien_we),
        .wdata (ien_wdata),
        .ien_q (ien_q)
    );

    assign en_rise = ien_we && ien_wdata[EN_THRE] && !ien_q[EN_THRE];

    irq_thre_latch u_thre (
        .clk       (clk),
        .rst       (rst),
        .thr_empty (thr_empty),
        .en_rise   (en_rise),
        .ack       (thre_ack),
        .pend_q    (thre_pend)
    );

    always_comb begin
        req       = '0;
        req.line  = ev_line_status;
        req.rxdat = ev_rx_data;
        req.tmo   = ev_rx_timeout;
        req.thre  = thre_pend;
        req.modem = ev_modem;
    end

    irq_prio_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .ien     (ien_q),
        .fifo_en (fifo_en),
        .grant   (grant),
        .iid     (iid_byte)
    );

    assign irq       = iid_byte[0];
    assign thre_ack  = iid_rd && grant.thre;
    assign pwrdn_req = ien_q[EN_PWRDN] && mcr_pd_en;

    assert_ack_on_thre_read_R9: assert property (@(posedge clk) disable iff (rst)
        thre_ack |-> (iid_rd && iid_byte[3:0] == 4'b0011));

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

    logic       clk = 1'b0;
    logic       rst;
    logic       ien_we;
    logic [7:0] ien_wdata;
    logic       mcr_pd_en, ev_line_status, ev_rx_data, ev_rx_timeout;
    logic       thr_empty, ev_modem, iid_rd, fifo_en;
    logic [7:0] iid_byte;
    logic       irq, thre_ack, pwrdn_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    logic [7:0] m_ien;
    logic       m_thrq, m_pend;

    always #5 clk = ~clk;

    uart_irq_ident i_uart_irq_ident (
        .clk(clk), .rst(rst), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .mcr_pd_en(mcr_pd_en), .ev_line_status(ev_line_status),
        .ev_rx_data(ev_rx_data), .ev_rx_timeout(ev_rx_timeout),
        .thr_empty(thr_empty), .ev_modem(ev_modem), .iid_rd(iid_rd),
        .fifo_en(fifo_en), .iid_byte(iid_byte), .irq(irq),
        .thre_ack(thre_ack), .pwrdn_req(pwrdn_req)
    );

    function automatic logic [7:0] exp_iid();
        logic [2:0] c;
        logic p;
        p = 1'b1;
        if (ev_line_status && m_ien[2])                     c = 3'b011;
        else if ((ev_rx_data || ev_rx_timeout) && m_ien[0]) c = ev_rx_timeout ? 3'b110 : 3'b010;
        else if (m_pend && m_ien[1])                        c = 3'b001;
        else if (ev_modem && m_ien[3])                      c = 3'b000;
        else begin c = 3'b000; p = 1'b0; end
        return {fifo_en, fifo_en, 2'b00, c, p};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        logic [7:0] e;
        logic       ack;
        #1;
        e   = exp_iid();
        ack = iid_rd && (e[3:0] == 4'b0011);
        chk({tag, " iid_byte"}, iid_byte, e);
        chk({tag, " irq R6"}, {7'd0, irq}, {7'd0, e[0]});
        chk({tag, " thre_ack R9"}, {7'd0, thre_ack}, {7'd0, ack});
        chk({tag, " pwrdn R10"}, {7'd0, pwrdn_req}, {7'd0, m_ien[5] && mcr_pd_en});
        @(posedge clk);
        if (rst) begin
            m_ien = 8'h00; m_thrq = 1'b1; m_pend = 1'b0;
        end else begin
            if (!thr_empty) m_pend = 1'b0;
            else if (!m_thrq || (ien_we && ien_wdata[1] && !m_ien[1])) m_pend = 1'b1;
            else if (ack) m_pend = 1'b0;
            m_thrq = thr_empty;
            if (ien_we) m_ien = ien_wdata & 8'h2F;
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        ien_we = 0; ien_wdata = 0; ev_line_status = 0; ev_rx_data = 0;
        ev_rx_timeout = 0; ev_modem = 0; iid_rd = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_ien = 0; m_thrq = 1; m_pend = 0;
        rst = 1; quiet(); thr_empty = 1; mcr_pd_en = 1; fifo_en = 0;
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst = 0;
        // R1 after reset: enables zero, all sources masked
        ev_line_status = 1; ev_modem = 1;
        step("R1 post-reset");
        quiet();
        // R2 write takes effect next cycle, reserved bits ignored
        ien_we = 1; ien_wdata = 8'hD4; ev_line_status = 1;
        step("R2 before");
        ien_we = 0;
        step("R2 after line");
        ien_we = 1; ien_wdata = 8'hFF;
        step("R2 write all");
        ien_we = 0; quiet();
        // R5 timeout over data
        ev_rx_data = 1; ev_rx_timeout = 1;
        step("R5 timeout");
        ev_rx_timeout = 0;
        step("R3 rxdata");
        // R4 line beats rx
        ev_line_status = 1;
        step("R4 line over rx");
        quiet();
        // R7 fifo bits
        fifo_en = 1;
        step("R7 fifo on");
        // R8 thre latch: set at start? (thr_empty was high since reset; enable rise set it)
        step("R8 thre pending");
        ev_modem = 1;
        // R9 read a non-thre code must not clear: raise line first
        ev_line_status = 1; iid_rd = 1;
        step("R9 read line");
        iid_rd = 0; ev_line_status = 0;
        step("R9 still thre");
        iid_rd = 1;
        step("R9 read thre");
        iid_rd = 0;
        step("R9 cleared shows modem");
        // R8 refill then empty again
        thr_empty = 0;
        step("R8 refill");
        thr_empty = 1;
        step("R8 edge");
        step("R8 set");
        // R8 re-arm via enable write while empty
        iid_rd = 1; step("R9 ack again"); iid_rd = 0;
        ien_we = 1; ien_wdata = 8'h2D; step("R8 disable thre");
        ien_wdata = 8'h2F; step("R8 enable rise");
        ien_we = 0; step("R8 re-armed");
        // R10
        mcr_pd_en = 0; step("R10 pd off");
        mcr_pd_en = 1; step("R10 pd on");
        // random mix R3 R4 R6 R7 R8 R9 R10
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom();
            ev_line_status = (r[2:0] == 3'd0);
            ev_rx_data     = r[3] & r[4];
            ev_rx_timeout  = (r[7:5] == 3'd0);
            ev_modem       = r[8];
            thr_empty      = (r[10:9] != 2'd0);
            iid_rd         = r[11];
            fifo_en        = r[12];
            mcr_pd_en      = r[13];
            ien_we         = (r[16:14] == 3'd0);
            ien_wdata      = r[31:24];
            step("R3/R4/R6 random");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule